// File: doc/BRIEF.md
# Compare-Triggered Sync Pulse Generator

The block turns a one-cycle compare-match event from a time counter into a single timed output pulse. Each accepted event starts a programmable delay. When the delay has run out the sync output goes high for a programmable number of clock cycles. Delay and width are both counted in cycles of the block's own clock, so at a 5 ns clock a width of 1000 gives a 5 µs pulse.

Software programs three registers through a simple write/read port: a control word holding two enable bits, the start delay, and the pulse width. The generator always re-arms itself. Every event that arrives while the generator is idle and both enables are set produces a pulse, with no acknowledge step. An event that arrives while a delay or pulse is in progress is dropped. Clearing either enable bit aborts whatever is under way.

Top module: `sync_pulse_gen`

## Requirements
- R1: After a synchronous active-low reset, `sync_out` is 0 and all three registers read back as 0.
- R2: Registers sit at `reg_addr` 0 (control), 1 (start delay) and 2 (width), and address 3 reads 0. A write takes effect at the clock edge where `reg_wr_en` is high. `reg_rd_data` returns the addressed register combinationally. Control keeps only bits 1:0 and reads 0 in every other bit.
- R3: A pulse can only appear when control bit 0 (unit enable) and control bit 1 (output enable) are both 1. With either bit clear, triggers produce no pulse.
- R4: With start delay 0, `sync_out` rises on the same clock edge that samples `trig` high.
- R5: With start delay D > 0, `sync_out` rises D edges after the edge that sampled `trig`.
- R6: With width W > 0, `sync_out` stays high for exactly W clock cycles and then returns low.
- R7: A width of 0 gives a pulse one clock cycle wide.
- R8: A trigger sampled while a delay or pulse is in progress, including the final high cycle, is ignored and does not restart or extend it.
- R9: A write that clears either enable bit forces `sync_out` low at that same edge and discards any pending delay or pulse. Setting the enables again does not resume the discarded pulse.
- R10: After a pulse completes, the generator re-arms by itself, so every later trigger on an idle generator yields its own pulse.
- R11: Delay and width are taken from the registers at the edge that accepts a trigger. Writes made later affect only the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Read data of the addressed register |
| trig | input | 1 | Compare-1 match event, one cycle high per match |
| sync_out | output | 1 | Registered sync pulse output |

## Verification
The embedded properties assume that `trig` and the register strobes are synchronous to `clk` and stable around the rising edge. They also assume that a disabling control write is the only way a running pulse ends early. The bench drives every input on the falling edge and writes the control register only in whole-cycle strobes, so both assumptions hold. The bench keeps delays and widths small enough that its integer reference model never wraps. It fires triggers both while the generator is idle and deliberately while it is busy.

// File: rtl/sync_pulse_pkg.sv
// Package: register addresses, control bit positions and the state type
// shared by the sync pulse generator modules.
package sync_pulse_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] REG_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_START = 2'd1;
    localparam logic [ADDR_W-1:0] REG_WIDTH = 2'd2;

    localparam int CTRL_BITS   = 2;
    localparam int BIT_UNIT_EN = 0;
    localparam int BIT_OUT_EN  = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_DELAY = 2'd1,
        SEQ_HIGH  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/sync_pulse_regs.sv
// Module: sync_pulse_regs
// Holds the control, start-delay and width registers and serves reads.
// It also produces run_en, the enable value that applies at the current edge
// (a pending control write wins), so a disable write aborts at once.
// Assumes CNT_W <= DATA_W and that CTRL_BITS fits in DATA_W.
module sync_pulse_regs
    import sync_pulse_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTRL_BITS-1:0] ctrl_q,
    output logic [CNT_W-1:0]  start_q,
    output logic [CNT_W-1:0]  width_q,
    output logic              run_en
);

    logic wr_ctrl;
    logic wr_start;
    logic wr_width;
    logic [CTRL_BITS-1:0] ctrl_eff;

    // Decode which register a write strobe targets.
    always_comb begin
        wr_ctrl  = wr_en && (addr == REG_CTRL);
        wr_start = wr_en && (addr == REG_START);
        wr_width = wr_en && (addr == REG_WIDTH);
    end

    // Register storage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            start_q <= '0;
            width_q <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= wdata[CTRL_BITS-1:0];
            if (wr_start) start_q <= wdata[CNT_W-1:0];
            if (wr_width) width_q <= wdata[CNT_W-1:0];
        end
    end

    // Enable seen by the sequencer at this edge: a control write overrides.
    always_comb begin
        ctrl_eff = wr_ctrl ? wdata[CTRL_BITS-1:0] : ctrl_q;
        run_en   = ctrl_eff[BIT_UNIT_EN] && ctrl_eff[BIT_OUT_EN];
    end

    // Read multiplexer, zero-extended to the data width.
    always_comb begin
        rd_data = '0;
        case (addr)
            REG_CTRL:  rd_data = DATA_W'(ctrl_q);
            REG_START: rd_data = DATA_W'(start_q);
            REG_WIDTH: rd_data = DATA_W'(width_q);
            default:   rd_data = '0;
        endcase
    end

    // R2: a control write is visible in the register after the edge.
    p_ctrl_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_CTRL) |=> (ctrl_q == $past(wdata[CTRL_BITS-1:0])));

    // R2: a start write lands unchanged.
    p_start_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_START) |=> (start_q == $past(wdata[CNT_W-1:0])));

endmodule

// File: rtl/sync_pulse_seq.sv
// Module: sync_pulse_seq
// Sequencer: accepts a trigger only when idle and enabled, counts the start
// delay, then holds the registered output high for the latched width.
// Width 0 is treated as 1. A low run_en returns it to idle at the same edge.
// Assumes trig is a synchronous, single-cycle event.
module sync_pulse_seq
    import sync_pulse_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             trig,
    input  logic [CNT_W-1:0] start_val,
    input  logic [CNT_W-1:0] width_val,
    output logic             pulse_q,
    output logic             busy
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] wlat_q, wlat_d;
    logic             pulse_d;
    logic [CNT_W-1:0] width_m1;

    // Width minus one, with a zero width folded to a single cycle.
    always_comb begin
        width_m1 = (width_val == '0) ? '0 : (width_val - ONE);
    end

    // Next-state logic for the delay/pulse sequence.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wlat_d  = wlat_q;
        pulse_d = pulse_q;
        if (!run_en) begin
            state_d = SEQ_IDLE;
            cnt_d   = '0;
            pulse_d = 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (trig) begin
                        wlat_d = width_m1;
                        if (start_val == '0) begin
                            state_d = SEQ_HIGH;
                            cnt_d   = width_m1;
                            pulse_d = 1'b1;
                        end else begin
                            state_d = SEQ_DELAY;
                            cnt_d   = start_val - ONE;
                        end
                    end
                end
                SEQ_DELAY: begin
                    if (cnt_q == '0) begin
                        state_d = SEQ_HIGH;
                        cnt_d   = wlat_q;
                        pulse_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                SEQ_HIGH: begin
                    if (cnt_q == '0) begin
                        state_d = SEQ_IDLE;
                        pulse_d = 1'b0;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: begin
                    state_d = SEQ_IDLE;
                    cnt_d   = '0;
                    pulse_d = 1'b0;
                end
            endcase
        end
    end

    // State, counter, latched width and output flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            wlat_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wlat_q  <= wlat_d;
            pulse_q <= pulse_d;
        end
    end

    // Busy flag for the top level.
    always_comb begin
        busy = (state_q != SEQ_IDLE);
    end

    // R9: a low enable leaves the sequencer idle with the output low.
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (!pulse_q && state_q == SEQ_IDLE));

    // R8: while the delay still runs, a trigger cannot restart it.
    p_delay_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_DELAY && cnt_q != '0 && run_en)
            |=> (state_q == SEQ_DELAY && cnt_q == $past(cnt_q) - ONE));

    // R6: the high phase counts down one per cycle with the output held.
    p_high_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_HIGH && cnt_q != '0 && run_en)
            |=> (pulse_q && cnt_q == $past(cnt_q) - ONE));

    // R4: an idle, enabled trigger with zero start raises the output next.
    p_zero_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && run_en && trig && start_val == '0) |=> pulse_q);

endmodule

// File: rtl/sync_pulse_gen.sv
// Module: sync_pulse_gen (top)
// Register block plus sequencer. The compare-1 event enters as trig and the
// registered sequencer output drives sync_out directly, so it cannot glitch.
// Assumes all inputs are synchronous to clk.
module sync_pulse_gen
    import sync_pulse_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rd_data,
    input  logic              trig,
    output logic              sync_out
);

    logic [CTRL_BITS-1:0] ctrl_q;
    logic [CNT_W-1:0]     start_q;
    logic [CNT_W-1:0]     width_q;
    logic                 run_en;
    logic                 busy;

    // Register file instance.
    sync_pulse_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rd_data (reg_rd_data),
        .ctrl_q  (ctrl_q),
        .start_q (start_q),
        .width_q (width_q),
        .run_en  (run_en)
    );

    // Delay and pulse sequencer instance.
    sync_pulse_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .trig      (trig),
        .start_val (start_q),
        .width_val (width_q),
        .pulse_q   (sync_out),
        .busy      (busy)
    );

    // R3: the output is high only while both stored enables are set.
    p_out_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> (ctrl_q[BIT_UNIT_EN] && ctrl_q[BIT_OUT_EN]));

    // R10: a high output always belongs to an active sequence.
    p_out_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |-> busy);

endmodule

// File: tb/sim_sync_pulse_gen.sv
module sim_sync_pulse_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rd_data;
    logic        trig = 1'b0;
    logic        sync_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycle = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    logic [1:0]  m_ctrl = 2'd0;
    logic [31:0] m_start = 32'd0;
    logic [31:0] m_width = 32'd0;
    int          m_d = 0;
    int          m_w = 0;
    bit          m_out = 1'b0;
    int          rises = 0;
    bit          prev_out = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sync_pulse_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rd_data (reg_rd_data),
        .trig        (trig),
        .sync_out    (sync_out)
    );

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: m_read = {30'd0, m_ctrl};
            2'd1: m_read = m_start;
            2'd2: m_read = m_width;
            default: m_read = 32'd0;
        endcase
    endfunction

    // Model update at every edge, then compare shortly after.
    always @(posedge clk) begin
        cycle++;
        if (!rst_n) begin
            m_ctrl = 0; m_start = 0; m_width = 0;
            m_d = 0; m_w = 0; m_out = 0;
        end else begin
            logic [1:0] en_src;
            en_src = (reg_wr_en && reg_addr == 2'd0) ? reg_wdata[1:0] : m_ctrl;
            if (en_src != 2'b11) begin
                m_d = 0; m_w = 0;                         // R9 abort
            end else if (m_d > 0 || m_w > 0) begin         // R8 busy
                if (m_d > 0) m_d--; else m_w--;
            end else if (trig) begin                       // R10 re-arm
                m_d = int'(m_start);
                m_w = (m_width == 0) ? 1 : int'(m_width);  // R7
            end
            m_out = (m_d == 0 && m_w > 0);
            if (reg_wr_en) begin                           // R2
                case (reg_addr)
                    2'd0: m_ctrl  = reg_wdata[1:0];
                    2'd1: m_start = reg_wdata;
                    2'd2: m_width = reg_wdata;
                    default: ;
                endcase
            end
        end
        #2;
        n_cmp++;
        if (sync_out !== m_out) begin
            n_bad++;
            $display("FAIL %s: sync_out=%0b expected %0b (cycle %0d)",
                     cur_req, sync_out, m_out, cycle);
        end
        n_cmp++;
        if (reg_rd_data !== m_read(reg_addr)) begin
            n_bad++;
            $display("FAIL R2: rd_data[%0d]=%h expected %h (cycle %0d)",
                     reg_addr, reg_rd_data, m_read(reg_addr), cycle);
        end
        if (sync_out && !prev_out) rises++;
        prev_out = sync_out;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); reg_addr = 2'(a);
        end

        cur_req = "R2";
        wr(2'd0, 32'hFFFF_FFFC);
        wr(2'd1, 32'h0000_1234);
        wr(2'd2, 32'h0000_0abc);
        for (int a = 0; a < 4; a++) begin
            @(negedge clk); reg_addr = 2'(a);
        end

        cur_req = "R3";
        wr(2'd1, 0); wr(2'd2, 4);
        wr(2'd0, 1); fire(); idle(8);
        wr(2'd0, 2); fire(); idle(8);
        check_int("R3", rises, 0);

        cur_req = "R4"; wr(2'd0, 3);
        fire(); idle(10);
        cur_req = "R6"; wr(2'd2, 9); fire(); idle(14);
        cur_req = "R5"; wr(2'd1, 7); wr(2'd2, 3); fire(); idle(14);
        cur_req = "R5"; wr(2'd1, 1); fire(); idle(8);
        cur_req = "R7"; wr(2'd1, 0); wr(2'd2, 0); fire(); idle(5);
        wr(2'd1, 2); fire(); idle(6);

        cur_req = "R8"; wr(2'd1, 2); wr(2'd2, 6);
        fire(); fire(); idle(3); fire(); idle(12);
        wr(2'd1, 0); wr(2'd2, 3);
        @(negedge clk); trig = 1'b1;                // trigger on every cycle
        idle(10); trig = 1'b0; idle(4);

        cur_req = "R9"; wr(2'd2, 20); fire(); idle(5);
        wr(2'd0, 1); idle(10); wr(2'd0, 3); idle(25);
        wr(2'd1, 6); fire(); idle(2); wr(2'd0, 2); wr(2'd0, 3); idle(15);

        cur_req = "R11"; wr(2'd1, 5); wr(2'd2, 4); fire();
        wr(2'd1, 1); wr(2'd2, 12); idle(12);

        cur_req = "R10"; wr(2'd1, 3); wr(2'd2, 4);
        rises = 0;
        for (int i = 0; i < 5; i++) begin
            fire(); idle(13);
        end
        check_int("R10", rises, 5);

        cur_req = "R1"; @(negedge clk); rst_n = 1'b0; idle(2);
        @(negedge clk); rst_n = 1'b1; idle(3);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run still active, expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule